// File: doc/BRIEF.md
# Host Bridge Bus-Status Interrupt Unit

This unit lives inside a bridge through which a host CPU reaches a shared, multi-master system bus. The bridge acts as a master on that bus. The unit watches host access strobes and compares them with the readiness of the bridge's bus master. It records three hazards in sticky flags:

- an overrun, which is an access to the system-bus range while the master is busy;
- an underrun, which is a host read that finishes before its data has arrived;
- an address error, which is an access to an undefined range.

A small register file exposes these flags to the host. It also holds a live bus-ready status bit and a per-flag enable mask. The unit drives one registered, active-high host interrupt.

Arbitration, the bus protocol engine and host bus timing are outside this unit. They reach it as plain one-cycle strobes and level inputs. Software polls the flags, or takes the interrupt, and then clears each flag by writing 1 to its bit.

Top module: `hbsi_top`

## Requirements
- R1: A read of offset 0 returns the bus-ready input in bit 0 (1 = master free, 0 = busy) and zero in bits 7:1.
- R2: An access strobe to the system-bus range while bus-ready is 0 sets flag bit 1 at the next clock edge. The same access with bus-ready 1, or an access outside that range, leaves bit 1 unchanged.
- R3: A read-completion strobe while read data is not yet valid sets flag bit 0. A completion with valid data leaves bit 0 unchanged.
- R4: An access strobe flagged as undefined-address sets flag bit 2. The flags are read at offset 1, in bits 2:0, with bits 7:3 reading zero.
- R5: Flags are set regardless of the enable register, so masked events remain visible at offset 1.
- R6: Flags are sticky. A write to offset 1 clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: When an event and a write-1-to-clear of the same flag bit occur in the same cycle, the flag stays set.
- R8: The enable register sits at offset 2, bits 2:0, with bit i enabling flag bit i. Bits 7:3 read as zero.
- R9: The interrupt output is 1 exactly when some flag bit and its enable bit are both 1. It is registered, so it follows a change in flags or enables one clock later.
- R10: After reset, the flags, the enables and the interrupt output are all zero.
- R11: Register read data is registered. The value selected by the address in one cycle appears on the read-data output after the next rising edge.
- R12: Writes to offset 0 or offset 3 change no state, and offset 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_ready_i | input | 1 | System-bus master free (1) or occupied (0) |
| host_acc_i | input | 1 | One-cycle strobe: a host access starts |
| host_sysbus_i | input | 1 | Qualifies host_acc_i: the address lies in the system-bus range |
| host_undef_i | input | 1 | Qualifies host_acc_i: the address lies in an undefined range |
| rd_done_i | input | 1 | One-cycle strobe: a host read completes |
| rd_data_valid_i | input | 1 | Requested read data is available |
| reg_addr_i | input | 2 | Register offset |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered register read data |
| irq_o | output | 1 | Combined host interrupt, active high |

## Verification
The hardest case to reach is a hazard strobe and a write-1-to-clear of the same flag arriving on the same edge. It needs a completion strobe with invalid data, or a busy-bus access, driven in exactly the cycle that carries the clearing write. The bench drives both from one cycle task, then reads the flag back to confirm it survived. It also covers a clear of one bit during an event on a different bit. A second delicate case is the one-cycle lag of the interrupt after an enable write. The bench samples the interrupt both in the cycle right after the write and one cycle later, so that both the old and the new value are checked.

// File: rtl/hbsi_pkg.sv
package hbsi_pkg;
  localparam int unsigned NUM_EVT = 3;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ADDR_W  = 2;

  localparam int unsigned EVT_UND = 0;
  localparam int unsigned EVT_OVR = 1;
  localparam int unsigned EVT_ERR = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFS_STATUS = 2'd0,
    OFS_FLAGS  = 2'd1,
    OFS_ENABLE = 2'd2,
    OFS_RSVD   = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/hbsi_event_detect.sv
module hbsi_event_detect
  import hbsi_pkg::*;
(
  input  logic               bus_ready_i,
  input  logic               host_acc_i,
  input  logic               host_sysbus_i,
  input  logic               host_undef_i,
  input  logic               rd_done_i,
  input  logic               rd_data_valid_i,
  output logic [NUM_EVT-1:0] evt_o
);
  always_comb begin
    evt_o          = '0;
    evt_o[EVT_UND] = rd_done_i & ~rd_data_valid_i;
    evt_o[EVT_OVR] = host_acc_i & host_sysbus_i & ~bus_ready_i;
    evt_o[EVT_ERR] = host_acc_i & host_undef_i;
  end
endmodule

// File: rtl/hbsi_flag_bank.sv
module hbsi_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;   // event beats clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/hbsi_regs.sv
module hbsi_regs
  import hbsi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_ready_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  input  logic [NUM_EVT-1:0] flag_i,
  output logic [NUM_EVT-1:0] clr_o,
  output logic [NUM_EVT-1:0] en_o,
  output logic [REG_W-1:0]   rdata_o
);
  localparam int unsigned PAD_W = REG_W - NUM_EVT;

  reg_ofs_e           ofs;
  logic [NUM_EVT-1:0] en_q;
  logic [REG_W-1:0]   rdata_q;
  logic [REG_W-1:0]   rdata_d;
  logic               unused_w;

  assign ofs      = reg_ofs_e'(reg_addr_i);
  assign unused_w = ^reg_wdata_i[REG_W-1:NUM_EVT];

  assign clr_o = (reg_we_i && ofs == OFS_FLAGS) ? reg_wdata_i[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          en_q <= '0;
    else if (reg_we_i && ofs == OFS_ENABLE) en_q <= reg_wdata_i[NUM_EVT-1:0];
  end

  always_comb begin
    unique case (ofs)
      OFS_STATUS: rdata_d = {{(REG_W-1){1'b0}}, bus_ready_i};
      OFS_FLAGS:  rdata_d = {{PAD_W{1'b0}}, flag_i};
      OFS_ENABLE: rdata_d = {{PAD_W{1'b0}}, en_q};
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/hbsi_irq_gen.sv
module hbsi_irq_gen #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_i & en_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/hbsi_top.sv
module hbsi_top
  import hbsi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_ready_i,
  input  logic              host_acc_i,
  input  logic              host_sysbus_i,
  input  logic              host_undef_i,
  input  logic              rd_done_i,
  input  logic              rd_data_valid_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] clr;
  logic [NUM_EVT-1:0] flag_q;
  logic [NUM_EVT-1:0] en_q;

  hbsi_event_detect u_evt (
    .bus_ready_i    (bus_ready_i),
    .host_acc_i     (host_acc_i),
    .host_sysbus_i  (host_sysbus_i),
    .host_undef_i   (host_undef_i),
    .rd_done_i      (rd_done_i),
    .rd_data_valid_i(rd_data_valid_i),
    .evt_o          (evt)
  );

  hbsi_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt),
    .clr_i (clr),
    .flag_o(flag_q)
  );

  hbsi_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_ready_i(bus_ready_i),
    .reg_addr_i (reg_addr_i),
    .reg_we_i   (reg_we_i),
    .reg_wdata_i(reg_wdata_i),
    .flag_i     (flag_q),
    .clr_o      (clr),
    .en_o       (en_q),
    .rdata_o    (reg_rdata_o)
  );

  hbsi_irq_gen #(.N(NUM_EVT)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .flag_i(flag_q),
    .en_i  (en_q),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/hbsi_checker.sv
module hbsi_checker
  import hbsi_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_ready_i,
  input logic               host_acc_i,
  input logic               host_sysbus_i,
  input logic               host_undef_i,
  input logic               rd_done_i,
  input logic               rd_data_valid_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic               reg_we_i,
  input logic [REG_W-1:0]   reg_wdata_i,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] flag_q,
  input logic [NUM_EVT-1:0] en_q
);
  AST_OVR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_acc_i && host_sysbus_i && !bus_ready_i |=> flag_q[EVT_OVR]); // R2
  AST_UND_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_i && !rd_data_valid_i |=> flag_q[EVT_UND]); // R3
  AST_ERR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_acc_i && host_undef_i |=> flag_q[EVT_ERR]); // R4
  AST_ERR_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q[EVT_ERR] && !(host_acc_i && host_undef_i) |=> !flag_q[EVT_ERR]); // R4
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q[EVT_OVR] && !(reg_we_i && reg_addr_i == OFS_FLAGS && reg_wdata_i[EVT_OVR])
    |=> flag_q[EVT_OVR]); // R6
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == OFS_ENABLE) |=> $stable(en_q)); // R8
  AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == |($past(flag_q) & $past(en_q))); // R9
endmodule

bind hbsi_top hbsi_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bus_ready_i    (bus_ready_i),
  .host_acc_i     (host_acc_i),
  .host_sysbus_i  (host_sysbus_i),
  .host_undef_i   (host_undef_i),
  .rd_done_i      (rd_done_i),
  .rd_data_valid_i(rd_data_valid_i),
  .reg_addr_i     (reg_addr_i),
  .reg_we_i       (reg_we_i),
  .reg_wdata_i    (reg_wdata_i),
  .irq_o          (irq_o),
  .flag_q         (flag_q),
  .en_q           (en_q)
);

// File: tb/hbsi_top_tb.sv
module hbsi_top_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_ready_i = 1'b1;
  logic       host_acc_i = 1'b0;
  logic       host_sysbus_i = 1'b0;
  logic       host_undef_i = 1'b0;
  logic       rd_done_i = 1'b0;
  logic       rd_data_valid_i = 1'b1;
  logic [1:0] reg_addr_i = 2'd0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  logic rd_issue = 1'b0;
  logic rd_pend = 1'b0;
  logic done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];

  always #2 clk_i = ~clk_i;  // 250 MHz

  hbsi_top u_dut (.*);

  always @(posedge clk_i) rd_pend <= rd_issue;

  // monitor: compare registered read data one cycle after a read request
  always @(negedge clk_i) begin
    if (rd_pend) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected read result actual %02h expected none", reg_rdata_o);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (reg_rdata_o !== it.exp) begin
          errors++;
          $display("FAIL %s actual %02h expected %02h", it.tag, reg_rdata_o, it.exp);
        end
      end
    end
  end

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq_o, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    reg_addr_i = a; rd_issue = 1'b1;
    @(negedge clk_i);
    rd_issue = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // one cycle of host strobes, optionally with a register write
  task automatic cyc(input logic acc, input logic sys, input logic undef,
                     input logic done_s, input logic valid,
                     input logic we, input logic [1:0] a, input logic [7:0] d);
    host_acc_i = acc; host_sysbus_i = sys; host_undef_i = undef;
    rd_done_i = done_s; rd_data_valid_i = valid;
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    host_acc_i = 1'b0; host_sysbus_i = 1'b0; host_undef_i = 1'b0;
    rd_done_i = 1'b0; rd_data_valid_i = 1'b1; reg_we_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_irq(1'b0, "R10 reset");
    rd(2'd1, 8'h00, "R10 flags after reset");
    rd(2'd2, 8'h00, "R10 enables after reset");

    bus_ready_i = 1'b1;
    rd(2'd0, 8'h01, "R1 status ready");
    bus_ready_i = 1'b0;
    rd(2'd0, 8'h00, "R1 status busy");

    bus_ready_i = 1'b1;
    cyc(1, 1, 0, 0, 1, 0, 2'd0, 8'h00);
    rd(2'd1, 8'h00, "R2 access while ready");
    bus_ready_i = 1'b0;
    cyc(1, 0, 0, 0, 1, 0, 2'd0, 8'h00);
    rd(2'd1, 8'h00, "R2 busy access outside range");
    cyc(1, 1, 0, 0, 1, 0, 2'd0, 8'h00);
    rd(2'd1, 8'h02, "R2 overrun sets bit1");
    bus_ready_i = 1'b1;
    chk_irq(1'b0, "R5 masked flag no irq");

    wr(2'd1, 8'h01);
    rd(2'd1, 8'h02, "R6 clear other bit keeps bit1");
    wr(2'd1, 8'h02);
    rd(2'd1, 8'h00, "R6 w1c clears bit1");

    cyc(0, 0, 0, 1, 1, 0, 2'd0, 8'h00);
    rd(2'd1, 8'h00, "R3 completion with valid data");
    cyc(0, 0, 0, 1, 0, 0, 2'd0, 8'h00);
    rd(2'd1, 8'h01, "R3 underrun sets bit0");
    cyc(1, 0, 1, 0, 1, 0, 2'd0, 8'h00);
    rd(2'd1, 8'h05, "R4 error sets bit2");

    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h07, "R8 enable readback");
    chk_irq(1'b1, "R9 irq after enable");
    wr(2'd2, 8'h00);
    chk_irq(1'b1, "R9 irq lags enable by one cycle");
    @(negedge clk_i);
    chk_irq(1'b0, "R9 irq falls after mask");

    wr(2'd2, 8'h04);
    @(negedge clk_i);
    chk_irq(1'b1, "R9 irq from bit2 only");
    wr(2'd1, 8'h04);
    rd(2'd1, 8'h01, "R6 clear bit2");
    chk_irq(1'b0, "R9 irq drops after clear");
    rd(2'd1, 8'h01, "R5 masked bit0 still visible");

    cyc(0, 0, 0, 1, 0, 1, 2'd1, 8'h01);
    rd(2'd1, 8'h01, "R7 event wins over clear");
    cyc(1, 0, 1, 0, 1, 1, 2'd1, 8'h01);
    rd(2'd1, 8'h04, "R7 clear bit0 while bit2 event");
    wr(2'd1, 8'h04);
    rd(2'd1, 8'h00, "R6 all clear");

    wr(2'd2, 8'h03);
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd2, 8'h03, "R12 enables unchanged");
    rd(2'd1, 8'h00, "R12 flags unchanged");
    rd(2'd3, 8'h00, "R12 offset3 reads zero");

    repeat (3) @(negedge clk_i);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R11 pending reads actual %0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule